// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits on the device side of a management link. It lets a host reach a large internal register space while the device answers on only one nonzero management address. In that mode the host sees just two registers there: a command register at select 0 and a data register at select 1. A command word carries an operation code, the internal device field and the register field. When the host writes a valid read or write command, the bridge raises a busy bit and runs one transfer on an internal valid/ready register bus. The busy bit then clears on its own. Read results land in the data register before busy drops. A write transfers whatever the host put in the data register beforehand. A command or data write that arrives while busy is still set is dropped, and a sticky error flag records it.

When the strap address is zero, the bridge steps aside. Each host access is passed straight to the internal bus with its own device and register fields, and the host port holds off new accesses until the transfer completes. The management serial framing is replaced here by a parallel valid/ready host port with a one-cycle done pulse.

Two state machines do the work. The bus engine has three states. It goes from EN_IDLE to EN_REQ on a start. It holds the request in EN_REQ until the internal ready arrives, then moves to EN_DONE. It spends exactly one cycle in EN_DONE and returns to EN_IDLE. The host sequencer has two states. HS_LOCAL serves the local registers and answers in one cycle. A direct access moves it from HS_LOCAL to HS_WAIT. The engine's EN_DONE cycle returns it from HS_WAIT to HS_LOCAL.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, h_ready is 1, h_done is 0, ib_valid is 0, cmd_err is 0, and both the command and data registers read 0.
- R2: In indirect mode, writing command bits 15:10 = 100110 with busy clear starts a single internal read. The internal device is command bits 9:5 and the register is bits 4:0. The read value is in the data register (select 1) by the time bit 15 of the command register reads 0.
- R3: In indirect mode, writing command bits 15:10 = 100101 with busy clear starts a single internal write. The fields are placed as in R2, and the write carries the value last loaded into the data register.
- R4: ib_valid stays high with stable fields until ib_ready. Completion takes effect at the clock edge after the handshake edge: in indirect mode busy clears there, and in direct mode h_done rises there.
- R5: A command whose bits 15:10 are neither code starts no internal transfer. It is stored with bit 15 reading 0 and bits 14:0 as written.
- R6: While busy, a command or data register write is ignored and sets cmd_err. cmd_err stays set until reset.
- R7: With strap_addr = 0, each host access runs one internal transfer with the host's own device, register, direction and data. h_ready stays 0 until h_done, and h_done returns the read value.
- R8: In indirect mode, an access to a device other than strap_addr, or to a select other than 0 or 1, has no effect. Such a read returns 0xFFFF.
- R9: A command register read returns the stored command word, with bit 15 showing the live busy state.
- R10: In indirect mode, every accepted host access gets h_done exactly one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 5 | Device's management address; zero selects direct mode |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Bridge can accept a host access |
| h_we | input | 1 | Host access is a write |
| h_dev | input | 5 | Host device address |
| h_rsel | input | 5 | Host register select |
| h_wdata | input | 16 | Host write data |
| h_done | output | 1 | One-cycle completion pulse |
| h_rdata | output | 16 | Read data, valid with h_done |
| cmd_err | output | 1 | Sticky flag: write dropped while busy |
| ib_valid | output | 1 | Internal bus request |
| ib_ready | input | 1 | Internal bus acknowledge |
| ib_we | output | 1 | Internal transfer is a write |
| ib_dev | output | 5 | Internal device address |
| ib_rsel | output | 5 | Internal register address |
| ib_wdata | output | 16 | Internal write data |
| ib_rdata | input | 16 | Internal read data, valid with ib_ready |

## Verification
The indirect path is exercised in several ways. Random mixes of reads and writes use random device and register fields and an internal responder whose latency varies from zero to three cycles. This separates a correctly placed field from a swapped or shifted one and shows that data is ready before busy drops. Directed sequences cover the remaining indirect cases: a second command and a data reload issued while a slow transfer is pending, unknown operation codes, commands without the busy bit, and accesses to foreign device addresses or unused selects. These show whether dropped writes really leave the internal bus, the data register and the command fields untouched. The direct mode is run with fixed short and long responder latencies, measuring the gap from handshake to done and whether h_ready stays low while a transfer is open.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_REQ,
        EN_DONE
    } eng_state_t;

    typedef enum logic {
        HS_LOCAL,
        HS_WAIT
    } host_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RD,
        OP_WR
    } op_t;

endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode
    import ibr_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 5,
    parameter logic [DW-2*AW-1:0] RD_OPC = 6'b100110,
    parameter logic [DW-2*AW-1:0] WR_OPC = 6'b100101
) (
    input  logic [DW-1:0] cmd,
    output op_t           op,
    output logic [AW-1:0] dev,
    output logic [AW-1:0] rsel
);
    localparam int OPC_LO = 2 * AW;

    logic [DW-OPC_LO-1:0] opc;

    assign opc  = cmd[DW-1:OPC_LO];
    assign dev  = cmd[OPC_LO-1:AW];
    assign rsel = cmd[AW-1:0];

    always_comb begin
        if (opc == RD_OPC)      op = OP_RD;
        else if (opc == WR_OPC) op = OP_WR;
        else                    op = OP_NONE;
    end
endmodule

// File: rtl/ibr_bus_engine.sv
module ibr_bus_engine
    import ibr_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          st_we,
    input  logic [AW-1:0] st_dev,
    input  logic [AW-1:0] st_rsel,
    input  logic [DW-1:0] st_wdata,
    output logic          ib_valid,
    output logic          ib_we,
    output logic [AW-1:0] ib_dev,
    output logic [AW-1:0] ib_rsel,
    output logic [DW-1:0] ib_wdata,
    input  logic          ib_ready,
    input  logic [DW-1:0] ib_rdata,
    output logic          done,
    output logic [DW-1:0] rdata_q
);
    eng_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_IDLE: if (start)    st_d = EN_REQ;
            EN_REQ:  if (ib_ready) st_d = EN_DONE;
            EN_DONE:               st_d = EN_IDLE;
            default:               st_d = EN_IDLE;
        endcase
    end

    assign ib_valid = (st_q == EN_REQ);
    assign done     = (st_q == EN_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ib_we    <= 1'b0;
            ib_dev   <= '0;
            ib_rsel  <= '0;
            ib_wdata <= '0;
            rdata_q  <= '0;
        end else begin
            if (start && st_q == EN_IDLE) begin
                ib_we    <= st_we;
                ib_dev   <= st_dev;
                ib_rsel  <= st_rsel;
                ib_wdata <= st_wdata;
            end
            if (ib_valid && ib_ready) rdata_q <= ib_rdata;
        end
    end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 5,
    parameter logic [DW-2*AW-1:0] RD_OPC = 6'b100110,
    parameter logic [DW-2*AW-1:0] WR_OPC = 6'b100101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] strap_addr,
    input  logic          h_valid,
    output logic          h_ready,
    input  logic          h_we,
    input  logic [AW-1:0] h_dev,
    input  logic [AW-1:0] h_rsel,
    input  logic [DW-1:0] h_wdata,
    output logic          h_done,
    output logic [DW-1:0] h_rdata,
    output logic          cmd_err,
    output logic          ib_valid,
    input  logic          ib_ready,
    output logic          ib_we,
    output logic [AW-1:0] ib_dev,
    output logic [AW-1:0] ib_rsel,
    output logic [DW-1:0] ib_wdata,
    input  logic [DW-1:0] ib_rdata
);
    localparam int            BUSY_BIT = DW - 1;
    localparam logic [AW-1:0] CMD_SEL  = '0;
    localparam logic [AW-1:0] DATA_SEL = AW'(1);

    host_state_t   hs_q, hs_d;
    logic [DW-1:0] cmd_q, data_q, local_rdata, eng_rdata;
    logic          busy, direct, accept, hit, cmd_wr, dat_wr;
    logic          ind_start, dir_start, eng_start, eng_done;
    op_t           new_op;
    logic [AW-1:0] new_dev, new_rsel;
    logic          st_we;
    logic [AW-1:0] st_dev, st_rsel;
    logic [DW-1:0] st_wdata;

    assign busy   = cmd_q[BUSY_BIT];
    assign direct = (strap_addr == '0);
    assign accept = h_valid && h_ready;
    assign hit    = !direct && (h_dev == strap_addr);
    assign cmd_wr = accept && hit && h_we && (h_rsel == CMD_SEL);
    assign dat_wr = accept && hit && h_we && (h_rsel == DATA_SEL);

    ibr_cmd_decode #(.DW(DW), .AW(AW), .RD_OPC(RD_OPC), .WR_OPC(WR_OPC)) u_dec (
        .cmd  (h_wdata),
        .op   (new_op),
        .dev  (new_dev),
        .rsel (new_rsel)
    );

    assign ind_start = cmd_wr && !busy && (new_op != OP_NONE);
    assign dir_start = accept && direct;
    assign eng_start = ind_start || dir_start;
    assign st_we     = direct ? h_we    : (new_op == OP_WR);
    assign st_dev    = direct ? h_dev   : new_dev;
    assign st_rsel   = direct ? h_rsel  : new_rsel;
    assign st_wdata  = direct ? h_wdata : data_q;

    ibr_bus_engine #(.DW(DW), .AW(AW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .st_we    (st_we),
        .st_dev   (st_dev),
        .st_rsel  (st_rsel),
        .st_wdata (st_wdata),
        .ib_valid (ib_valid),
        .ib_we    (ib_we),
        .ib_dev   (ib_dev),
        .ib_rsel  (ib_rsel),
        .ib_wdata (ib_wdata),
        .ib_ready (ib_ready),
        .ib_rdata (ib_rdata),
        .done     (eng_done),
        .rdata_q  (eng_rdata)
    );

    always_comb begin
        if (!hit)                    local_rdata = '1;
        else if (h_rsel == CMD_SEL)  local_rdata = cmd_q;
        else if (h_rsel == DATA_SEL) local_rdata = data_q;
        else                         local_rdata = '1;
    end

    // host sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= HS_LOCAL;
        else        hs_q <= hs_d;
    end

    always_comb begin
        hs_d = hs_q;
        unique case (hs_q)
            HS_LOCAL: if (dir_start) hs_d = HS_WAIT;
            HS_WAIT:  if (eng_done)  hs_d = HS_LOCAL;
            default:                 hs_d = HS_LOCAL;
        endcase
    end

    assign h_ready = (hs_q == HS_LOCAL);

    // host sequencer: registered outputs and local register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_done  <= 1'b0;
            h_rdata <= '0;
            cmd_q   <= '0;
            data_q  <= '0;
            cmd_err <= 1'b0;
        end else begin
            h_done <= 1'b0;
            if (accept && !direct) begin
                h_done  <= 1'b1;
                h_rdata <= local_rdata;
            end else if (hs_q == HS_WAIT && eng_done) begin
                h_done  <= 1'b1;
                h_rdata <= eng_rdata;
            end

            if ((cmd_wr || dat_wr) && busy) cmd_err <= 1'b1;

            if (cmd_wr && !busy)
                cmd_q <= {new_op != OP_NONE, h_wdata[BUSY_BIT-1:0]};
            else if (eng_done)
                cmd_q[BUSY_BIT] <= 1'b0;

            if (dat_wr && !busy)
                data_q <= h_wdata;
            else if (eng_done && busy && !ib_we)
                data_q <= eng_rdata;
        end
    end
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] strap_addr,
    input logic          h_valid,
    input logic          h_ready,
    input logic          h_done,
    input logic          cmd_err,
    input logic          busy,
    input logic          ib_valid,
    input logic          ib_ready,
    input logic          ib_we,
    input logic [AW-1:0] ib_dev,
    input logic [AW-1:0] ib_rsel,
    input logic [DW-1:0] ib_wdata
);
    // R4: request held with stable fields until acknowledged
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_valid && !ib_ready) |=> (ib_valid && $stable({ib_we, ib_dev, ib_rsel, ib_wdata})));

    // R4: busy drops at the edge after the handshake edge
    a_r4_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((strap_addr != '0) && ib_valid && ib_ready) |=> busy ##1 !busy);

    // R2, R3, R5: no internal traffic in indirect mode unless busy
    a_r5_no_idle_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        ((strap_addr != '0) && !busy) |-> !ib_valid);

    // R6: error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R7: host held off while a direct transfer is open
    a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((strap_addr == '0) && ib_valid) |-> !h_ready);

    // R10: indirect accesses answer in one cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((strap_addr != '0) && h_valid && h_ready) |=> h_done);
endmodule

bind ind_reg_bridge ibr_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_addr (strap_addr),
    .h_valid    (h_valid),
    .h_ready    (h_ready),
    .h_done     (h_done),
    .cmd_err    (cmd_err),
    .busy       (busy),
    .ib_valid   (ib_valid),
    .ib_ready   (ib_ready),
    .ib_we      (ib_we),
    .ib_dev     (ib_dev),
    .ib_rsel    (ib_rsel),
    .ib_wdata   (ib_wdata)
);

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
    localparam logic [4:0] S = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  strap;
    logic        h_valid, h_we;
    logic [4:0]  h_dev, h_rsel;
    logic [15:0] h_wdata;
    logic        h_ready, h_done, cmd_err;
    logic [15:0] h_rdata;
    logic        ib_valid, ib_we, ib_ready;
    logic [4:0]  ib_dev, ib_rsel;
    logic [15:0] ib_wdata, ib_rdata;

    int total = 0, bad = 0;
    int cyc = 0, hs_cnt = 0, hs_cyc = 0;
    int slv_lat = 0, wcnt = 0;
    bit rdy_in_wait;
    logic [15:0] mem [0:1023];

    always #4 clk = ~clk;

    ind_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap),
        .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we), .h_dev(h_dev),
        .h_rsel(h_rsel), .h_wdata(h_wdata), .h_done(h_done), .h_rdata(h_rdata),
        .cmd_err(cmd_err), .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_we(ib_we),
        .ib_dev(ib_dev), .ib_rsel(ib_rsel), .ib_wdata(ib_wdata), .ib_rdata(ib_rdata)
    );

    function automatic logic [15:0] mk_cmd(input logic [5:0] opc, input logic [4:0] d, input logic [4:0] r);
        return {opc, d, r};
    endfunction

    function automatic logic [15:0] seed_val(input int i);
        return 16'(i * 37) ^ 16'hA5C3;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // internal bus responder
    initial begin
        ib_ready = 1'b0;
        ib_rdata = '0;
        forever begin
            @(negedge clk);
            if (ib_ready) ib_ready = 1'b0;
            else if (ib_valid) begin
                if (wcnt >= slv_lat) begin
                    ib_ready = 1'b1;
                    ib_rdata = mem[{ib_dev, ib_rsel}];
                    wcnt = 0;
                end else wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ib_valid && ib_ready) begin
            hs_cnt <= hs_cnt + 1;
            hs_cyc <= cyc;
            if (ib_we) mem[{ib_dev, ib_rsel}] <= ib_wdata;
        end
    end

    task automatic host_acc(input logic we, input logic [4:0] d, input logic [4:0] r,
                            input logic [15:0] wd, output logic [15:0] rd, output int lat);
        @(negedge clk);
        h_valid = 1'b1; h_we = we; h_dev = d; h_rsel = r; h_wdata = wd;
        while (!h_ready) @(negedge clk);
        @(negedge clk);
        h_valid = 1'b0;
        lat = 1;
        rdy_in_wait = 1'b0;
        while (!h_done && lat < 500) begin
            if (h_ready) rdy_in_wait = 1'b1;
            @(negedge clk);
            lat++;
        end
        rd = h_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        int l;
        for (int k = 0; k < 100; k++) begin
            host_acc(1'b0, S, 5'd0, 16'h0, v, l);
            if (!v[15]) break;
        end
    endtask

    task automatic ind_write(input logic [4:0] d, input logic [4:0] r, input logic [15:0] val);
        logic [15:0] v;
        int l;
        wait_idle();
        host_acc(1'b1, S, 5'd1, val, v, l);
        host_acc(1'b1, S, 5'd0, mk_cmd(6'b100101, d, r), v, l);
        wait_idle();
    endtask

    task automatic ind_read(input logic [4:0] d, input logic [4:0] r, output logic [15:0] res);
        logic [15:0] v;
        int l;
        wait_idle();
        host_acc(1'b1, S, 5'd0, mk_cmd(6'b100110, d, r), v, l);
        wait_idle();
        host_acc(1'b0, S, 5'd1, 16'h0, res, l);
    endtask

    task automatic do_reset(input logic [4:0] sa);
        rst_n = 1'b0; strap = sa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, e;
        int l, h0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = seed_val(i);
        h_valid = 1'b0; h_we = 1'b0; h_dev = '0; h_rsel = '0; h_wdata = '0;

        // ---------------- indirect mode ----------------
        do_reset(S);
        chk(h_ready && !h_done && !ib_valid && !cmd_err, "R1 reset outputs",
            {h_ready, h_done, ib_valid, cmd_err}, 4'b1000);
        host_acc(1'b0, S, 5'd0, 16'h0, v, l);
        chk(v == 16'h0, "R1 command reg after reset", v, 0);
        chk(l == 1, "R10 one-cycle local access", l, 1);
        host_acc(1'b0, S, 5'd1, 16'h0, v, l);
        chk(v == 16'h0, "R1 data reg after reset", v, 0);

        // R2 directed read and R9 readback
        slv_lat = 2;
        e = mem[{5'd17, 5'd9}];
        ind_read(5'd17, 5'd9, v);
        chk(v == e, "R2 indirect read data", v, e);
        host_acc(1'b0, S, 5'd0, 16'h0, v, l);
        chk(v == mk_cmd(6'b000110, 5'd17, 5'd9), "R9 command readback, busy clear",
            v, mk_cmd(6'b000110, 5'd17, 5'd9));

        // R3 directed write
        ind_write(5'd30, 5'd31, 16'hC0DE);
        chk(mem[{5'd30, 5'd31}] == 16'hC0DE, "R3 indirect write lands", mem[{5'd30, 5'd31}], 16'hC0DE);
        chk(mem[{5'd31, 5'd30}] == seed_val({5'd31, 5'd30}), "R3 swapped fields untouched",
            mem[{5'd31, 5'd30}], seed_val({5'd31, 5'd30}));

        // R9 busy visible while a slow transfer is open
        slv_lat = 6;
        host_acc(1'b1, S, 5'd0, mk_cmd(6'b100110, 5'd2, 5'd4), v, l);
        host_acc(1'b0, S, 5'd0, 16'h0, v, l);
        chk(v == mk_cmd(6'b100110, 5'd2, 5'd4), "R9 busy bit set while open", v, mk_cmd(6'b100110, 5'd2, 5'd4));
        wait_idle();

        // R5 unknown code and missing busy bit
        wait_idle();
        h0 = hs_cnt;
        host_acc(1'b1, S, 5'd0, mk_cmd(6'b100111, 5'd5, 5'd6), v, l);
        repeat (10) @(negedge clk);
        host_acc(1'b0, S, 5'd0, 16'h0, v, l);
        chk(v == mk_cmd(6'b000111, 5'd5, 5'd6), "R5 unknown code stored, busy 0", v, mk_cmd(6'b000111, 5'd5, 5'd6));
        host_acc(1'b1, S, 5'd0, mk_cmd(6'b000110, 5'd7, 5'd8), v, l);
        repeat (10) @(negedge clk);
        chk(hs_cnt == h0, "R5 no internal transfer", hs_cnt - h0, 0);
        chk(!cmd_err, "R6 no error before any collision", cmd_err, 0);

        // R6 writes while busy are dropped
        slv_lat = 6;
        h0 = hs_cnt;
        host_acc(1'b1, S, 5'd1, 16'hBEEF, v, l);
        host_acc(1'b1, S, 5'd0, mk_cmd(6'b100101, 5'd9, 5'd10), v, l);
        host_acc(1'b1, S, 5'd1, 16'h1234, v, l);
        host_acc(1'b1, S, 5'd0, mk_cmd(6'b100110, 5'd11, 5'd12), v, l);
        wait_idle();
        chk(cmd_err, "R6 sticky error raised", cmd_err, 1);
        chk(mem[{5'd9, 5'd10}] == 16'hBEEF, "R6 write used original data", mem[{5'd9, 5'd10}], 16'hBEEF);
        host_acc(1'b0, S, 5'd1, 16'h0, v, l);
        chk(v == 16'hBEEF, "R6 data reg kept", v, 16'hBEEF);
        host_acc(1'b0, S, 5'd0, 16'h0, v, l);
        chk(v == mk_cmd(6'b000101, 5'd9, 5'd10), "R6 command reg kept", v, mk_cmd(6'b000101, 5'd9, 5'd10));
        chk(hs_cnt - h0 == 1, "R6 one transfer only", hs_cnt - h0, 1);
        repeat (5) @(negedge clk);
        chk(cmd_err, "R6 error still set", cmd_err, 1);

        // R8 foreign device and unused select
        h0 = hs_cnt;
        host_acc(1'b0, S + 5'd1, 5'd1, 16'h0, v, l);
        chk(v == 16'hFFFF, "R8 foreign device reads ones", v, 16'hFFFF);
        host_acc(1'b0, S, 5'd5, 16'h0, v, l);
        chk(v == 16'hFFFF, "R8 unused select reads ones", v, 16'hFFFF);
        chk(l == 1, "R10 one-cycle unused select", l, 1);
        host_acc(1'b1, S + 5'd1, 5'd1, 16'h7777, v, l);
        host_acc(1'b1, S + 5'd1, 5'd0, mk_cmd(6'b100101, 5'd1, 5'd1), v, l);
        host_acc(1'b1, S, 5'd2, 16'h6666, v, l);
        repeat (10) @(negedge clk);
        host_acc(1'b0, S, 5'd1, 16'h0, v, l);
        chk(v == 16'hBEEF, "R8 writes elsewhere have no effect", v, 16'hBEEF);
        chk(hs_cnt == h0, "R8 no internal transfer", hs_cnt - h0, 0);

        // random indirect mix (R2, R3)
        for (int it = 0; it < 40; it++) begin
            logic [4:0] d, r;
            logic [15:0] wv;
            d = 5'($urandom);
            r = 5'($urandom);
            wv = 16'($urandom);
            slv_lat = int'($urandom % 4);
            if ($urandom % 2 == 0) begin
                ind_write(d, r, wv);
                chk(mem[{d, r}] == wv, "R3 random write", mem[{d, r}], wv);
            end else begin
                e = mem[{d, r}];
                ind_read(d, r, v);
                chk(v == e, "R2 random read", v, e);
            end
        end

        // ---------------- direct mode ----------------
        do_reset(5'd0);
        chk(h_ready && !h_done && !ib_valid && !cmd_err, "R1 reset outputs, direct",
            {h_ready, h_done, ib_valid, cmd_err}, 4'b1000);
        slv_lat = 0;
        host_acc(1'b1, 5'd7, 5'd19, 16'h5AA5, v, l);
        chk(mem[{5'd7, 5'd19}] == 16'h5AA5, "R7 direct write", mem[{5'd7, 5'd19}], 16'h5AA5);
        chk(cyc - hs_cyc == 2, "R4 done one edge after handshake, fast", cyc - hs_cyc, 2);
        slv_lat = 3;
        e = mem[{5'd0, 5'd1}];
        host_acc(1'b0, 5'd0, 5'd1, 16'h0, v, l);
        chk(v == e, "R7 direct read", v, e);
        chk(cyc - hs_cyc == 2, "R4 done one edge after handshake, slow", cyc - hs_cyc, 2);
        chk(!rdy_in_wait, "R7 h_ready low while open", rdy_in_wait, 0);
        for (int it = 0; it < 10; it++) begin
            logic [4:0] d, r;
            d = 5'($urandom);
            r = 5'($urandom);
            slv_lat = int'($urandom % 4);
            e = mem[{d, r}];
            host_acc(1'b0, d, r, 16'h0, v, l);
            chk(v == e, "R7 random direct read", v, e);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule